// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block keeps frame time for a full-speed USB host. A down-counter of bit times runs from a programmable frame interval to zero. When it hits zero it reloads, advances a 16-bit frame number and marks the new frame with a start-of-frame pulse. Host software loads the interval, the periodic start point and the low-speed threshold through simple write strobes. It reads back the interval word, a remaining-time word and the frame number.

The interval word also carries a toggle bit and a full-speed largest-packet field. Software flips the toggle on every interval write. The counter copies the toggle into its own remaining-time word at the next reload, so software can tell when a new interval has taken effect. A periodic-start flag tells the scheduler that enough of the frame has elapsed for periodic traffic to begin. A second pulse marks each change of the top bit of the frame number, so a wider frame count can be kept elsewhere.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval word reads frame interval 11999 in bits 13:0, largest-packet size 0 in bits 30:16 and toggle 0 in bit 31. A write to the interval word stores those three fields and is visible on the next cycle. Bits 15:14 always read 0.
- R2: While the run enable is high, each bit-time tick decrements a non-zero remaining count by one. The remaining word shows the count in bits 13:0 and the remaining toggle in bit 31, with all other bits 0. After reset the count is 11999 and the toggle is 0.
- R3: A tick that finds the count at zero reloads the count from the interval field and copies the interval toggle into the remaining toggle. The same tick increments the frame number, wrapping 0xFFFF to 0, and the start-of-frame output is high for exactly the following cycle. The frame number resets to 0.
- R4: An interval write made during a frame does not alter the running count. The new interval and toggle are used only at the next reload, and a write in the same cycle as a reload still reloads the old value.
- R5: The frame-overflow output pulses for one cycle, in the cycle the start-of-frame pulse is high, whenever bit 15 of the frame number changes (0x7FFF to 0x8000 and 0xFFFF to 0x0000). It is low otherwise.
- R6: The periodic-start flag sets when a decrement leaves the count at or below the periodic start value, and it clears on reload. If the start value is at or above the interval, the flag sets at the first decrement of the frame.
- R7: While the run enable is low, ticks have no effect: the count, the remaining toggle and the frame number hold, and neither pulse is emitted.
- R8: The periodic start value (14 bits, reset 0) and the low-speed threshold (15 bits, reset 0x0628) are written by their strobes and read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Frame counting enable |
| bit_tick | input | 1 | One pulse per bit time |
| intv_we | input | 1 | Interval word write strobe |
| intv_wdata | input | 32 | Interval word write data |
| pstart_we | input | 1 | Periodic start write strobe |
| pstart_wdata | input | 14 | Periodic start write data |
| lsthr_we | input | 1 | Low-speed threshold write strobe |
| lsthr_wdata | input | 15 | Low-speed threshold write data |
| intv_q | output | 32 | Interval word readback |
| remain_q | output | 32 | Remaining-time word (count and toggle) |
| frame_num | output | 16 | Frame number |
| pstart_q | output | 14 | Periodic start readback |
| lsthr_q | output | 15 | Low-speed threshold readback |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame number bit-15 change pulse |
| periodic_ok | output | 1 | Periodic traffic may start |

## Verification
A corrupted count shows up on the remaining word in the very next cycle. It also shifts every later start-of-frame pulse, so an error in the reload value or the zero detection moves the frame boundaries within one frame. A stale toggle or a missed interval update is visible at the first reload after the write. A wrong frame-number carry appears at once on the frame number. It is caught at the latest when the frame count crosses 0x8000 or wraps past 0xFFFF, which the bench forces by running one-bit frames for more than 65536 ticks.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int          CW      = 14,
  parameter int          FNW     = 16,
  parameter logic [13:0] FI_RST  = 14'd11999,
  parameter logic [13:0] PS_RST  = 14'd0,
  parameter logic [14:0] LS_RST  = 15'h0628
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        bit_tick,
  input  logic        intv_we,
  input  logic [31:0] intv_wdata,
  input  logic        pstart_we,
  input  logic [13:0] pstart_wdata,
  input  logic        lsthr_we,
  input  logic [14:0] lsthr_wdata,
  output logic [31:0] intv_q,
  output logic [31:0] remain_q,
  output logic [15:0] frame_num,
  output logic [13:0] pstart_q,
  output logic [14:0] lsthr_q,
  output logic        sof_pulse,
  output logic        fno_pulse,
  output logic        periodic_ok
);
  localparam int TOP = FNW - 1;

  logic [CW-1:0]  fi_q, cnt_q, ps_q;
  logic [14:0]    mps_q, ls_q;
  logic           itog_q, rtog_q;
  logic [FNW-1:0] fn_q;
  logic           sof_q, fno_q, pf_q;

  wire            step  = run && bit_tick;
  wire            wrap  = step && (cnt_q == '0);
  wire [FNW-1:0]  fn_nx = fn_q + 1'b1;
  wire [CW-1:0]   cnt_m = cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_q   <= FI_RST;
      mps_q  <= '0;
      itog_q <= 1'b0;
      ps_q   <= PS_RST;
      ls_q   <= LS_RST;
      cnt_q  <= FI_RST;
      rtog_q <= 1'b0;
      fn_q   <= '0;
      sof_q  <= 1'b0;
      fno_q  <= 1'b0;
      pf_q   <= 1'b0;
    end else begin
      if (intv_we) begin
        fi_q   <= intv_wdata[13:0];
        mps_q  <= intv_wdata[30:16];
        itog_q <= intv_wdata[31];
      end
      if (pstart_we) ps_q <= pstart_wdata;
      if (lsthr_we)  ls_q <= lsthr_wdata;
      sof_q <= wrap;
      fno_q <= wrap && (fn_nx[TOP] != fn_q[TOP]);
      if (wrap) begin
        cnt_q  <= fi_q;
        rtog_q <= itog_q;
        fn_q   <= fn_nx;
        pf_q   <= 1'b0;
      end else if (step) begin
        cnt_q <= cnt_m;
        if (cnt_m <= ps_q) pf_q <= 1'b1;
      end
    end
  end

  assign intv_q      = {itog_q, mps_q, 2'b00, fi_q};
  assign remain_q    = {rtog_q, 17'd0, cnt_q};
  assign frame_num   = fn_q;
  assign pstart_q    = ps_q;
  assign lsthr_q     = ls_q;
  assign sof_pulse   = sof_q;
  assign fno_pulse   = fno_q;
  assign periodic_ok = pf_q;

  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && !sof_q);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> sof_q && cnt_q == $past(fi_q) && rtog_q == $past(itog_q)
             && fn_q == $past(fn_q) + 1'b1);

  p_fno_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fno_q |-> sof_q && (fn_q[TOP-1:0] == '0));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> !pf_q);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q) && $stable(fn_q) && $stable(rtog_q) && !sof_q && !fno_q);
endmodule

// File: tb/usb_frame_timer_tb_top.sv
module usb_frame_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, bit_tick = 1'b0;
  logic        intv_we = 1'b0, pstart_we = 1'b0, lsthr_we = 1'b0;
  logic [31:0] intv_wdata = '0;
  logic [13:0] pstart_wdata = '0;
  logic [14:0] lsthr_wdata = '0;
  logic [31:0] intv_q, remain_q;
  logic [15:0] frame_num;
  logic [13:0] pstart_q;
  logic [14:0] lsthr_q;
  logic        sof_pulse, fno_pulse, periodic_ok;

  int n_total = 0, n_fail = 0;
  bit cmp_on = 1'b0;
  int fno_seen = 0, sof_seen = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
    .intv_we(intv_we), .intv_wdata(intv_wdata),
    .pstart_we(pstart_we), .pstart_wdata(pstart_wdata),
    .lsthr_we(lsthr_we), .lsthr_wdata(lsthr_wdata),
    .intv_q(intv_q), .remain_q(remain_q), .frame_num(frame_num),
    .pstart_q(pstart_q), .lsthr_q(lsthr_q),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse), .periodic_ok(periodic_ok));

  // behavioural reference
  int m_fi, m_mps, m_it, m_ps, m_ls, m_cnt, m_rt, m_fn, m_sof, m_fno, m_pf;

  task automatic m_reset();
    m_fi = 11999; m_mps = 0; m_it = 0; m_ps = 0; m_ls = 'h628;
    m_cnt = 11999; m_rt = 0; m_fn = 0; m_sof = 0; m_fno = 0; m_pf = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      m_sof = 0; m_fno = 0;
      if (run && bit_tick) begin
        if (m_cnt == 0) begin
          int nfn;
          nfn   = (m_fn + 1) % 65536;
          m_fno = ((nfn / 32768) != (m_fn / 32768)) ? 1 : 0;
          m_fn  = nfn;
          m_cnt = m_fi; m_rt = m_it; m_sof = 1; m_pf = 0;
        end else begin
          m_cnt = m_cnt - 1;
          if (m_cnt <= m_ps) m_pf = 1;
        end
      end
      if (intv_we) begin
        m_fi = intv_wdata[13:0]; m_mps = intv_wdata[30:16]; m_it = intv_wdata[31];
      end
      if (pstart_we) m_ps = pstart_wdata;
      if (lsthr_we)  m_ls = lsthr_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 interval word", intv_q, {m_it[0], m_mps[14:0], 2'b00, m_fi[13:0]});
      chk("R2 remaining word", remain_q, {m_rt[0], 17'd0, m_cnt[13:0]});
      chk("R3 frame number", {16'd0, frame_num}, m_fn);
      chk("R3 start of frame", {31'd0, sof_pulse}, m_sof);
      chk("R5 overflow pulse", {31'd0, fno_pulse}, m_fno);
      chk("R6 periodic flag", {31'd0, periodic_ok}, m_pf);
      chk("R8 periodic start", {18'd0, pstart_q}, m_ps);
      chk("R8 low-speed threshold", {17'd0, lsthr_q}, m_ls);
      if (fno_pulse) fno_seen++;
      if (sof_pulse) sof_seen++;
    end
  end

  task automatic wr_intv(input logic [31:0] v);
    @(negedge clk); intv_we = 1'b1; intv_wdata = v;
    @(negedge clk); intv_we = 1'b0;
  endtask

  task automatic cycles(input int n, input int tick_pct, input int run_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = ($urandom_range(99) < tick_pct);
      run      = ($urandom_range(99) < run_pct);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++; n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R2, R3, R8)
    chk("R1 reset interval", intv_q, 32'h0000_2EDF);
    chk("R2 reset remaining", remain_q, 32'h0000_2EDF);
    chk("R3 reset frame", {16'd0, frame_num}, 32'd0);
    chk("R8 reset thresholds", {3'd0, lsthr_q, pstart_q}, {3'd0, 15'h0628, 14'd0});
    cmp_on = 1'b1;
    // R7: ticks with run low
    cycles(50, 100, 0);
    // R1/R4: interval write mid-frame, bits 15:14 discarded
    wr_intv({1'b1, 15'd64, 2'b11, 14'd9});
    @(negedge clk); pstart_we = 1'b1; pstart_wdata = 14'd3; lsthr_we = 1'b1; lsthr_wdata = 15'h1234;
    @(negedge clk); pstart_we = 1'b0; lsthr_we = 1'b0;
    cycles(12100, 100, 100);
    // irregular ticks
    cycles(600, 60, 100);
    // R4: mid-frame rewrite with toggle flipped
    wr_intv({1'b0, 15'd8, 2'b00, 14'd4});
    cycles(300, 70, 100);
    // R7: run toggling
    cycles(400, 80, 50);
    // R6: start value above interval
    @(negedge clk); pstart_we = 1'b1; pstart_wdata = 14'd20;
    @(negedge clk); pstart_we = 1'b0;
    cycles(200, 100, 100);
    // R5: one-bit frames across 0x8000 and the 16-bit wrap
    wr_intv({1'b1, 15'd0, 2'b00, 14'd0});
    cycles(10, 100, 100);
    f0 = fno_seen;
    cycles(66000, 100, 100);
    chk("R5 overflow pulses in long run", fno_seen - f0, 2);
    n_total++;
    if (sof_seen < 66000) begin
      n_fail++;
      $display("FAIL R3 sof count actual=%0d expected>=66000", sof_seen);
    end
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule